// File: doc/BRIEF.md
# Vectored Dual-Output Interrupt Controller

This block gathers up to 64 interrupt request lines and steers each one, under a per-source route bit, to one of two processor-facing outputs: a normal request (`irq`) or a fast request (`fiq`). Each source has an enable bit and a polarity bit. The polarity bit is applied first, so an active-low level source can be presented as active. The result is then gated by the enable bit and by a global mask bit for each output.

For the normal path, a table of 32 priority slots is kept. Each slot names one source and has a valid bit. Slot 0 is the most urgent. `irq_vec` gives the number of the most urgent valid slot whose source is pending on the normal path. When none is, it gives 32. For the fast path, each source carries a level bit that places it in an upper or a lower tier. `fiq_vec` names the lowest-numbered pending source of the upper tier. If the upper tier has no pending source, it names the lowest-numbered one of the lower tier. When nothing is pending on the fast path, it gives 64.

Configuration goes through a single-cycle write port. All registers take effect on the clock edge that captures the write. Outputs are combinational from the registers and the source inputs.

Top module: `intc_vec`

## Requirements
- R1: While `rst_n` is low, and right after it, all enable, route, polarity, level and mask bits are 0 and all slots are invalid. Therefore `irq`=0, `fiq`=0, `irq_vec`=32 and `fiq_vec`=64.
- R2: A pending source with route bit 1 drives only `fiq`. With route bit 0 it drives only `irq`. Route bits are at addresses 8 (sources 31..0) and 9 (sources 63..32).
- R3: A source whose enable bit is 0 affects neither output nor vector. Enable bits are at addresses 0 (sources 31..0) and 1 (sources 63..32).
- R4: With polarity bit 1 a source is pending when its input is low. With polarity bit 0 it is pending when its input is high. Polarity bits are at addresses 16 and 17.
- R5: `irq` is 1 whenever any enabled, unmasked normal-routed source is pending, even if no slot names that source.
- R6: `irq_vec` is the lowest slot number s whose slot is valid and names a pending, enabled, normal-routed source. It is 32 when there is none. Slot s is written at address 32+s: bit 6 is valid and bits 5:0 are the source number.
- R7: A slot with valid bit 0 never matches, whatever source it names.
- R8: `fiq_vec` is the lowest-numbered pending fast source whose level bit is 1. If there is none, it is the lowest-numbered pending fast source with level bit 0. It is 64 when nothing is pending. Level bits are at addresses 24 and 25.
- R9: Address 31 holds the mask: bit 0 forces `irq`=0 and `irq_vec`=32, and bit 1 forces `fiq`=0 and `fiq_vec`=64.
- R10: A write changes the outputs from the cycle after the capturing clock edge. Before that edge the old setting still applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 7 | Register address |
| wr_data | input | 32 | Register write data |
| src | input | 64 | Interrupt source levels |
| irq | output | 1 | Normal interrupt request |
| fiq | output | 1 | Fast interrupt request |
| irq_vec | output | 6 | Winning slot number, 32 if none |
| fiq_vec | output | 7 | Winning fast source number, 64 if none |

## Verification
The normal and the fast path can both resolve in the same cycle from different sources. Several table rows drive one normal-routed source and one fast-routed source together. In those rows all four outputs are compared against values derived separately for each path, so a routing leak that mixes the paths shows up as a wrong vector on the other side. A write that lands while a source is already pending is also checked on both sides of the capturing edge.

// File: rtl/intc_vec.sv
module intc_vec #(
  parameter int NSRC  = 64,
  parameter int NSLOT = 32,
  parameter int DW    = 32,
  localparam int SIW  = $clog2(NSRC),
  localparam int SVW  = $clog2(NSLOT) + 1,
  localparam int NW   = NSRC / DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [6:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [NSRC-1:0] src,
  output logic           irq,
  output logic           fiq,
  output logic [SVW-1:0] irq_vec,
  output logic [SIW:0]   fiq_vec
);
  localparam int A_EN = 0, A_RT = 8, A_POL = 16, A_LVL = 24, A_MSK = 31, A_SLOT = 32;

  logic [NSRC-1:0] en_q, route_q, pol_q, lvl_q;
  logic [1:0]      msk_q;
  logic [SIW:0]    slot_q [NSLOT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= '0; route_q <= '0; pol_q <= '0; lvl_q <= '0; msk_q <= '0;
      for (int s = 0; s < NSLOT; s++) slot_q[s] <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < NW; w++) begin
        if (wr_addr == 7'(A_EN + w))  en_q[w*DW +: DW]    <= wr_data;
        if (wr_addr == 7'(A_RT + w))  route_q[w*DW +: DW] <= wr_data;
        if (wr_addr == 7'(A_POL + w)) pol_q[w*DW +: DW]   <= wr_data;
        if (wr_addr == 7'(A_LVL + w)) lvl_q[w*DW +: DW]   <= wr_data;
      end
      if (wr_addr == 7'(A_MSK)) msk_q <= wr_data[1:0];
      for (int s = 0; s < NSLOT; s++)
        if (wr_addr == 7'(A_SLOT + s)) slot_q[s] <= wr_data[SIW:0];
    end
  end

  wire [NSRC-1:0] pend  = (src ^ pol_q) & en_q;
  wire [NSRC-1:0] ipend = pend & ~route_q & {NSRC{~msk_q[0]}};
  wire [NSRC-1:0] fpend = pend &  route_q & {NSRC{~msk_q[1]}};

  assign irq = |ipend;
  assign fiq = |fpend;

  always_comb begin
    irq_vec = SVW'(NSLOT);
    for (int s = NSLOT - 1; s >= 0; s--)
      if (slot_q[s][SIW] && ipend[slot_q[s][SIW-1:0]]) irq_vec = SVW'(s);
  end

  always_comb begin
    fiq_vec = (SIW+1)'(NSRC);
    for (int i = NSRC - 1; i >= 0; i--)
      if (fpend[i] && !lvl_q[i]) fiq_vec = (SIW+1)'(i);
    for (int i = NSRC - 1; i >= 0; i--)
      if (fpend[i] && lvl_q[i]) fiq_vec = (SIW+1)'(i);
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!irq && !fiq));
  assert_vec_implies_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vec != SVW'(NSLOT)) |-> irq);
  assert_fvec_implies_fiq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_vec != (SIW+1)'(NSRC)) |-> fiq);
  assert_mask_silences_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_addr == 7'(A_MSK) && wr_data[0]) |-> (!irq && irq_vec == SVW'(NSLOT)));
  assert_mask_silences_fiq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en && wr_addr == 7'(A_MSK) && wr_data[1]) |-> (!fiq && fiq_vec == (SIW+1)'(NSRC)));
endmodule

// File: tb/intc_vec_tb.sv
`timescale 1ns/1ps
module intc_vec_tb;
  logic        clk = 0, rst_n = 0, wr_en = 0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] src = '0;
  logic        irq, fiq;
  logic [5:0]  irq_vec;
  logic [6:0]  fiq_vec;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  intc_vec u_dut (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .src, .irq, .fiq, .irq_vec, .fiq_vec);

  typedef struct packed {
    logic [63:0] s; logic i; logic f; logic [5:0] iv; logic [6:0] fv;
  } row_t;
  localparam logic [63:0] Q = 64'h20;
  localparam row_t TBL [12] = '{
    {Q,                      1'b0, 1'b0, 6'd32, 7'd64},
    {Q | 64'h8,              1'b1, 1'b0, 6'd1,  7'd64},
    {Q | 64'h8 | 64'h100000, 1'b1, 1'b0, 6'd0,  7'd64},
    {Q | 64'h400 | 64'h8,    1'b1, 1'b0, 6'd1,  7'd64},
    {Q | 64'h80,             1'b1, 1'b0, 6'd32, 7'd64},
    {Q | (64'h1 << 61),      1'b0, 1'b0, 6'd32, 7'd64},
    {Q | (64'h1 << 41),      1'b0, 1'b1, 6'd32, 7'd41},
    {Q | (64'h1 << 41) | (64'h1 << 44), 1'b0, 1'b1, 6'd32, 7'd44},
    {Q | (64'h1 << 45) | (64'h1 << 42), 1'b0, 1'b1, 6'd32, 7'd42},
    {64'h0,                  1'b1, 1'b0, 6'd32, 7'd64},
    {Q | 64'h400 | (64'h1 << 43), 1'b1, 1'b1, 6'd2, 7'd43},
    {Q | 64'h100000 | (64'h1 << 44) | (64'h1 << 63), 1'b1, 1'b1, 6'd0, 7'd44}
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag, logic i, logic f, logic [5:0] iv, logic [6:0] fv);
    chk({tag, " irq"}, 64'(irq), 64'(i));
    chk({tag, " fiq"}, 64'(fiq), 64'(f));
    chk({tag, " irq_vec"}, 64'(irq_vec), 64'(iv));
    chk({tag, " fiq_vec"}, 64'(fiq_vec), 64'(fv));
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    src = '1;
    #1 chk_all("R1 in reset", 0, 0, 32, 64);
    rst_n = 1;
    @(negedge clk); #1 chk_all("R1 after reset", 0, 0, 32, 64);

    src = Q;
    wr(0, 32'hFFFF_FFFF); wr(1, 32'h0FFF_FFFF);
    wr(9, 32'h0000_FF00); wr(16, 32'h20); wr(25, 32'h1000);
    wr(32, 32'h40 | 20); wr(33, 32'h40 | 3); wr(34, 32'h40 | 10);
    wr(35, 32'h07); wr(36, 32'h40 | 41);

    // R2 R3 R4 R5 R6 R7 R8 table walk
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); src = TBL[k].s;
      #1 chk_all($sformatf("R2/R6/R8 row %0d", k), TBL[k].i, TBL[k].f, TBL[k].iv, TBL[k].fv);
    end

    // R9 masking
    @(negedge clk); src = Q | 64'h8 | (64'h1 << 41);
    wr(31, 32'h1);
    #1 chk_all("R9 irq masked", 0, 1, 32, 41);
    wr(31, 32'h2);
    #1 chk_all("R9 fiq masked", 1, 0, 1, 64);
    wr(31, 32'h0);
    #1 chk_all("R9 unmasked", 1, 1, 1, 41);

    // R10 write timing against a pending source
    @(negedge clk); src = Q | 64'h8;
    wr_en = 1; wr_addr = 0; wr_data = 32'hFFFF_FFF7;
    #1 chk_all("R10 before edge", 1, 0, 1, 64);
    @(negedge clk); wr_en = 0;
    #1 chk_all("R10 after edge R3", 0, 0, 32, 64);
    wr(0, 32'hFFFF_FFFF);

    // R7 slot becomes valid
    src = Q | 64'h80;
    wr(35, 32'h40 | 7);
    #1 chk_all("R7 slot validated", 1, 0, 3, 64);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk); #1 chk_all("R1 re-reset", 0, 0, 32, 64);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule